// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer

The block holds four independent 32-bit down-counters behind a simple memory-mapped register port. Software writes and reads 32-bit words at byte addresses, and reads come back combinationally in the same cycle. Each channel has four registers: a start value, the live count, a control word, and a pending reload value. Each channel can run in one of three modes. It can wrap freely as an elapsed-time source. It can reload on a fixed period as a tick source. It can fire once and stop as an event timer.

All counting advances only on cycles where the shared `tick_en` strobe is high. A per-channel divider can slow this further, by 16 or by 256. Each channel reports expiry through a sticky raw status bit. A mask selects which of those bits reach the single combined interrupt line. Because the counters run downward, software derives elapsed time by negating the value it reads.

Top module: `quad_down_timer`

## Requirements
- R1: After reset every register reads zero, no channel counts and `irq` is low.
- R2: Bits [1:0] of the address are ignored. Shared registers sit at word 0x00 (interrupt enable mask, read/write, bit n for channel n), 0x04 (raw status, read-only), 0x08 (raw AND mask, read-only) and 0x0C (clear, write-only, reads zero). Channel n sits at 0x10+0x10*n with start value at +0x0, live count at +0x4, control at +0x8 and pending reload at +0xC. Any other address reads zero.
- R3: A write to a channel's start value sets the start value, the live count and the pending reload value to the written word in the next cycle.
- R4: Control bit 7 enables counting, bit 6 selects periodic reload, bits 3:2 select the divider, bit 1 selects 32-bit width (clear means 16-bit), and bit 0 selects one-shot, which takes precedence over bit 6. Bits 5:4 and 31:8 read as zero. An enabled channel whose count is not zero decrements by one on each step.
- R5: In free-running mode (bits 6 and 0 clear), a step taken at count zero loads the all-ones value of the selected width and sets the channel's raw status bit.
- R6: In periodic mode, a step taken at count zero loads the pending reload value (cut to the selected width) and sets the raw status bit. Writing the pending reload register leaves the live count unchanged.
- R7: In one-shot mode, a step taken at count zero sets the raw status bit and clears control bit 7. The count then stays at zero.
- R8: In 16-bit mode only the low 16 bits take part in counting, zero detection and wrapping, and the live count reads with bits 31:16 zero. The start value register still reads back all 32 written bits.
- R9: A step occurs on a `tick_en` cycle that completes a run of 1, 16 or 256 such cycles, for divider codes 00, 01 and 10/11. The per-channel divide counter restarts when the channel is disabled, or when its control or start value register is written.
- R10: A raw status bit stays set until software writes 1 to the matching bit of the clear register. An expiry in the same cycle as a clear leaves the bit set. Writes to the raw status address change nothing.
- R11: `irq` is high exactly when some raw status bit is set and its mask bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count strobe; counting advances only when high |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address for reads and writes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench targets four corner cases: the step taken at count zero in each of the three modes, a write to the pending reload register partway through a period, a clear landing in the same cycle as a new expiry, and 16-bit wrapping with stale upper bits present in the start value. A design that mishandled these would stop a periodic channel, or pick up the new reload value too early. It could also lose an interrupt whose clear raced its re-expiry, or let bits 31:16 leak into the count. The prescaler runs with a gated, alternating strobe, and the bench changes the divider and the enable mid-run. An off-by-one in the divide count, or a divider that fails to restart, shows up as a step landing on the wrong cycle.

// File: rtl/quad_down_timer.sv
module quad_down_timer #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic              irq
);

  logic [NUM_CH-1:0] mask_q, raw_q, expire, clr;
  logic [31:0]       chan_rd [NUM_CH];

  wire [ADDR_W-5:0] grp = addr[ADDR_W-1:4];
  wire [1:0]        sel = addr[3:2];
  wire              unused_lo = &{1'b0, addr[1:0]};

  assign clr = (wr_en && grp == '0 && sel == 2'd3) ? wr_data[NUM_CH-1:0] : '0;
  assign irq = |(raw_q & mask_q);

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic [31:0] ld_q, val_q, bg_q;
    logic [7:0]  ct_q, pre_q;

    wire        hit   = wr_en && (int'(grp) == n + 1);
    wire        wr_ld = hit && sel == 2'd0;
    wire        wr_ct = hit && sel == 2'd2;
    wire        wr_bg = hit && sel == 2'd3;
    wire [31:0] wmask = ct_q[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    wire [7:0]  lim   = (ct_q[3:2] == 2'b00) ? 8'd0 :
                        (ct_q[3:2] == 2'b01) ? 8'd15 : 8'd255;
    wire        step  = ct_q[7] && tick_en && pre_q == lim;
    wire [31:0] cur   = val_q & wmask;

    assign expire[n] = step && cur == '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ld_q  <= '0;
        val_q <= '0;
        bg_q  <= '0;
        ct_q  <= '0;
        pre_q <= '0;
      end else begin
        if (!ct_q[7] || wr_ld || wr_ct) pre_q <= '0;
        else if (tick_en)               pre_q <= (pre_q == lim) ? 8'd0 : pre_q + 8'd1;

        if (wr_ld) begin
          ld_q  <= wr_data;
          val_q <= wr_data;
          bg_q  <= wr_data;
        end else if (step) begin
          if (cur != '0)    val_q <= cur - 32'd1;
          else if (ct_q[0]) ct_q[7] <= 1'b0;
          else if (ct_q[6]) val_q <= bg_q & wmask;
          else              val_q <= wmask;
        end

        if (wr_bg) bg_q <= wr_data;
        if (wr_ct) ct_q <= wr_data[7:0] & 8'hCF;
      end
    end

    assign chan_rd[n] = (sel == 2'd0) ? ld_q :
                        (sel == 2'd1) ? cur :
                        (sel == 2'd2) ? {24'd0, ct_q} : bg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      raw_q  <= '0;
    end else begin
      if (wr_en && grp == '0 && sel == 2'd0) mask_q <= wr_data[NUM_CH-1:0];
      raw_q <= (raw_q & ~clr) | expire;
    end
  end

  always_comb begin
    rd_data = '0;
    if (grp == '0) begin
      case (sel)
        2'd0:    rd_data[NUM_CH-1:0] = mask_q;
        2'd1:    rd_data[NUM_CH-1:0] = raw_q;
        2'd2:    rd_data[NUM_CH-1:0] = raw_q & mask_q;
        default: rd_data = '0;
      endcase
    end
    for (int n = 0; n < NUM_CH; n++)
      if (int'(grp) == n + 1) rd_data = chan_rd[n];
  end

endmodule

// File: rtl/timer_checks.sv
module timer_checks #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              irq,
  input logic [ADDR_W-1:0] addr,
  input logic [NUM_CH-1:0] wd,
  input logic [NUM_CH-1:0] mask,
  input logic [NUM_CH-1:0] raw,
  input logic [NUM_CH-1:0] expire
);

  wire clr_wr  = wr_en && addr == ADDR_W'(12);
  wire mask_wr = wr_en && addr == '0;

  p_irq_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);

  p_mask_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask == $past(wd)));

  for (genvar k = 0; k < NUM_CH; k++) begin : g_k
    p_raw_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      expire[k] |=> raw[k]);

    p_raw_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && wd[k] && !expire[k]) |=> !raw[k]);

    p_raw_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (raw[k] && !(clr_wr && wd[k])) |=> raw[k]);

    p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!raw[k] && !expire[k]) |=> !raw[k]);
  end

endmodule

bind quad_down_timer timer_checks #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .irq(irq), .addr(addr),
  .wd(wr_data[NUM_CH-1:0]), .mask(mask_q), .raw(raw_q), .expire(expire)
);

// File: tb/tb_quad_down_timer.sv
`timescale 1ns/1ps
module tb_quad_down_timer;
  logic        clk = 0, rst_n = 0, tick_en = 0, wr_en = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic        irq;
  int vecs = 0, bad = 0;
  bit running = 0;
  string phase = "R1 reset state";

  quad_down_timer dut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
                       .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq));

  always #10 clk = ~clk;

  logic [31:0] m_ld[4], m_val[4], m_bg[4];
  logic [7:0]  m_ct[4], m_pre[4];
  logic [3:0]  m_mask, m_raw;

  function automatic logic [31:0] wmask_of(input logic [7:0] c);
    return c[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  function automatic logic [31:0] mread(input logic [7:0] a);
    int ch = int'(a[7:4]) - 1;
    if (a[7:4] == 0) begin
      case (a[3:2])
        0: return {28'd0, m_mask};
        1: return {28'd0, m_raw};
        2: return {28'd0, m_raw & m_mask};
        default: return 0;
      endcase
    end
    if (ch > 3) return 0;
    case (a[3:2])
      0: return m_ld[ch];
      1: return m_val[ch] & wmask_of(m_ct[ch]);
      2: return {24'd0, m_ct[ch]};
      default: return m_bg[ch];
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) begin
        m_ld[k] = 0; m_val[k] = 0; m_bg[k] = 0; m_ct[k] = 0; m_pre[k] = 0;
      end
      m_mask = 0; m_raw = 0;
    end else begin
      logic [3:0] nraw;
      nraw = m_raw & ~((wr_en && addr[7:2] == 6'd3) ? wr_data[3:0] : 4'd0);
      for (int k = 0; k < 4; k++) begin
        automatic logic [31:0] wm = wmask_of(m_ct[k]);
        automatic int lim = (m_ct[k][3:2] == 0) ? 1 : (m_ct[k][3:2] == 1) ? 16 : 256;
        automatic bit hit = wr_en && int'(addr[7:4]) == k + 1;
        automatic bit en = m_ct[k][7];
        automatic bit stp = en && tick_en && (int'(m_pre[k]) + 1 == lim);
        automatic logic [31:0] cur = m_val[k] & wm;
        if (!en || (hit && (addr[3:2] == 0 || addr[3:2] == 2))) m_pre[k] = 0;
        else if (tick_en) m_pre[k] = stp ? 8'd0 : m_pre[k] + 8'd1;
        if (hit && addr[3:2] == 0) begin
          m_ld[k] = wr_data; m_val[k] = wr_data; m_bg[k] = wr_data;
        end else if (stp) begin
          if (cur != 0) m_val[k] = cur - 1;
          else begin
            nraw[k] = 1;
            if (m_ct[k][0]) m_ct[k][7] = 0;
            else if (m_ct[k][6]) m_val[k] = m_bg[k] & wm;
            else m_val[k] = wm;
          end
        end
        if (hit && addr[3:2] == 3) m_bg[k] = wr_data;
        if (hit && addr[3:2] == 2) m_ct[k] = wr_data[7:0] & 8'hCF;
      end
      if (wr_en && addr[7:2] == 0) m_mask = wr_data[3:0];
      m_raw = nraw;
    end
  end

  always @(negedge clk) if (rst_n && running) begin
    vecs++;
    if (rd_data !== mread(addr)) begin
      bad++;
      $display("FAIL %s: addr %h rd_data=%h expected %h", phase, addr, rd_data, mread(addr));
    end
    vecs++;
    if (irq !== |(m_raw & m_mask)) begin
      bad++;
      $display("FAIL R11 irq during %s: irq=%b expected %b", phase, irq, |(m_raw & m_mask));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #1; wr_en = 1; addr = a; wr_data = d;
    @(negedge clk); #1; wr_en = 0;
  endtask

  task automatic look(input logic [7:0] a, input int n);
    @(negedge clk); #1; addr = a;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1; rst_n = 1; running = 1;
    phase = "R1 reset state";
    for (int a = 0; a < 8'h54; a += 4) look(8'(a), 1);

    phase = "R3 load write";
    wr(8'h10, 32'd5);
    look(8'h14, 1); look(8'h1C, 1); look(8'h10, 1);
    phase = "R2 low address bits ignored / unused address";
    look(8'h13, 1); look(8'h50, 1); look(8'hF0, 1);

    phase = "R5 free-running wrap";
    wr(8'h18, 32'hFFFF_FF82);
    look(8'h18, 1);
    tick_en = 1; look(8'h14, 9); tick_en = 0;
    look(8'h04, 1);
    phase = "R11 mask and masked status";
    wr(8'h00, 32'h1); look(8'h08, 2);
    phase = "R10 clear and read-only raw";
    wr(8'h0C, 32'h1); look(8'h04, 2);
    wr(8'h04, 32'hF); look(8'h04, 1);
    wr(8'h18, 32'h0);

    phase = "R6 periodic reload";
    wr(8'h00, 32'hF);
    wr(8'h20, 32'd2); wr(8'h28, 32'hC2);
    tick_en = 1; look(8'h24, 2);
    wr(8'h2C, 32'd7); look(8'h24, 14);
    tick_en = 0; wr(8'h0C, 32'h2);
    phase = "R10 clear racing expiry";
    wr(8'h20, 32'd0);
    tick_en = 1;
    wr(8'h0C, 32'h2); look(8'h04, 3);
    tick_en = 0; wr(8'h28, 32'h0); wr(8'h0C, 32'h2); look(8'h04, 1);

    phase = "R7 one-shot stop";
    wr(8'h30, 32'd2); wr(8'h38, 32'hC3);
    tick_en = 1; look(8'h34, 6); look(8'h38, 2); look(8'h04, 1);
    tick_en = 0; wr(8'h0C, 32'h4);

    phase = "R8 16-bit width";
    wr(8'h40, 32'h0001_0002); wr(8'h48, 32'h80);
    tick_en = 1; look(8'h44, 6); look(8'h40, 1);
    wr(8'h48, 32'h82); look(8'h44, 3);
    tick_en = 0; wr(8'h48, 32'h0); wr(8'h0C, 32'h8);

    phase = "R9 divide by 16 with gated strobe";
    wr(8'h10, 32'd4); wr(8'h18, 32'h86);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #1; tick_en = i[0]; addr = 8'h14;
    end
    phase = "R9 divide by 256 and restart on load";
    tick_en = 1;
    wr(8'h18, 32'h8A); look(8'h14, 300);
    wr(8'h10, 32'd3); look(8'h14, 600);
    phase = "R9 code 11 and disable mid-run";
    wr(8'h18, 32'h8E); look(8'h14, 100);
    wr(8'h18, 32'h0E); look(8'h14, 5);
    wr(8'h18, 32'h8E); look(8'h14, 700);
    tick_en = 0;
    phase = "R4 control readback";
    look(8'h18, 1); look(8'h08, 1);
    running = 0;
    finish_run();
  end
endmodule